// File: doc/BRIEF.md
# Wrapped 3x3 Tower Neighbourhood Summer

The block accepts a grid of signed tower energies one row per beat and, for every tower, adds up the towers in the 3x3 neighbourhood around it. Each result is compared against a runtime seed threshold to give a seed flag. It is then limited to an unsigned 12-bit range and sent out one row per beat. The row direction is cyclic: the last row of the grid and the first row are neighbours. The columns form two independent halves, so a window that would reach across the outer edge of the grid, or across the seam between the halves, is cut short there.

Rows enter on a valid/ready stream. The beat that carries row 0 is marked with a frame-start flag. The sums for row r-1 can be computed once row r has arrived, so they appear in the output register on the cycle after row r is accepted. Rows 0 and 1 are kept aside until the last row has been seen. After the final input row the block emits the last row and then row 0 on its own, without input traffic, so a frame's outputs come out in the order 1, 2, ..., 31, 0. Each output beat carries its row index.

Back-pressure works as follows. An output beat stays valid and unchanged until `out_ready` is high at a clock edge. The input is ready only when the output register is empty or is being drained in that cycle. The input is also held off during the two end-of-frame flush beats. The seed threshold is sampled when an output row is formed, so it must be held steady while a frame is in flight.

Top module: `tower_block_summer`

## Requirements
- R1: An inner column (any column other than 0, 5, 6 and 11) outputs the sum of the 9 towers formed by the previous, own and next rows in the previous, own and next columns.
- R2: Columns 0 and 6 add only their own column and the one to their right. Columns 5 and 11 add only their own column and the one to their left. Each of these windows holds 6 towers, and no window crosses between column 5 and column 6.
- R3: The row neighbours of row r are rows (r+1) mod 32 and (r+31) mod 32, so rows 0 and 31 contribute to each other's sums.
- R4: The seed flag of a tower is 1 exactly when its unclamped window sum is strictly greater than the signed threshold `seed_thr`. A sum equal to the threshold gives 0.
- R5: The reported sum is 0 when the window sum is negative and 4095 when it exceeds 4095. Otherwise it is the window sum itself.
- R6: A frame's outputs come in the row order 1 to 31 and then 0, each with its row index on `out_row_idx`. The sums for row r-1 (r at least 2) become valid on the cycle after input row r is accepted. A complete frame gives exactly 32 output beats.
- R7: While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. `in_ready` is also low while the two end-of-frame rows (31, then 0) are being emitted.
- R8: An input beat without `in_sof` that arrives while no frame is open is accepted and dropped, and it produces no output.
- R9: A beat with `in_sof` always starts a new frame as row 0, even in the middle of a frame. The partial frame gives no further output, and no output is valid on the cycle after that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input row beat is valid |
| in_ready | output | 1 | Block can take an input row this cycle |
| in_sof | input | 1 | This beat is row 0 of a new frame |
| in_row | input | 192 | Twelve signed 16-bit towers, column c at bits [16c+15:16c] |
| seed_thr | input | 16 | Signed seed threshold |
| out_valid | output | 1 | Output row beat is valid |
| out_ready | input | 1 | Consumer takes the output row this cycle |
| out_row_idx | output | 5 | Row index of the output beat |
| out_sum | output | 144 | Twelve clamped 12-bit sums, column c at bits [12c+11:12c] |
| out_seed | output | 12 | Seed flag per column, bit c for column c |

## Verification
The hardest state to reach from the ports is the end-of-frame flush. There, rows 31 and 0 are formed from stored rows while input is held off, and the output must also be kept stable under a stalled consumer. The stimulus gets there by streaming complete frames while the consumer's ready follows a pseudo-random pattern, and by holding ready low early in a frame until the input side has visibly stalled. Grids with isolated towers next to the wrap rows and the half seam, grids with negative towers, and grids with saturating towers drive every window shape through the seed comparison and both clamp limits. Each output cell is compared against a model of the window that the bench computes itself.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int DEF_ROWS    = 32;
  localparam int DEF_COLS    = 12;
  localparam int DEF_HALF    = 6;
  localparam int DEF_TOWER_W = 16;
  localparam int DEF_OUT_W   = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LAST  = 2'd2,
    ST_FIRST = 2'd3
  } tbs_state_e;

  typedef enum logic [1:0] {
    SEL_RUN   = 2'd0,
    SEL_LAST  = 2'd1,
    SEL_FIRST = 2'd2
  } tbs_sel_e;
endpackage

// File: rtl/tbs_cell.sv
// One output cell: horizontal sum of column partial sums, seed test, clamp.
module tbs_cell #(
  parameter int TOWER_W = 16,
  parameter int SUM_W   = 20,
  parameter int OUT_W   = 12
) (
  input  logic signed [SUM_W-1:0]   vs_l,
  input  logic signed [SUM_W-1:0]   vs_c,
  input  logic signed [SUM_W-1:0]   vs_r,
  input  logic signed [TOWER_W-1:0] thr,
  output logic [OUT_W-1:0]          sum_o,
  output logic                      seed_o
);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2 ** OUT_W) - 1);

  logic signed [SUM_W-1:0] total;
  logic signed [SUM_W-1:0] thr_x;

  assign total  = vs_l + vs_c + vs_r;
  assign thr_x  = {{(SUM_W-TOWER_W){thr[TOWER_W-1]}}, thr};
  // seed decision uses the unclamped sum
  assign seed_o = (total > thr_x);

  always_comb begin
    if (total < 0)         sum_o = '0;
    else if (total > MAXV) sum_o = '1;
    else                   sum_o = total[OUT_W-1:0];
  end
endmodule

// File: rtl/tbs_rowsum.sv
// Combinational row of window sums; the column position picks the window shape.
module tbs_rowsum #(
  parameter int COLS    = 12,
  parameter int HALF    = 6,
  parameter int TOWER_W = 16,
  parameter int SUM_W   = 20,
  parameter int OUT_W   = 12
) (
  input  logic [COLS*TOWER_W-1:0]   up_row,
  input  logic [COLS*TOWER_W-1:0]   mid_row,
  input  logic [COLS*TOWER_W-1:0]   dn_row,
  input  logic signed [TOWER_W-1:0] thr,
  output logic [COLS*OUT_W-1:0]     sums,
  output logic [COLS-1:0]           seeds
);
  localparam int EXT = SUM_W - TOWER_W;

  logic signed [SUM_W-1:0] vsum  [COLS];
  logic signed [SUM_W-1:0] lterm [COLS];
  logic signed [SUM_W-1:0] rterm [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [TOWER_W-1:0] tu, tm, td;
    assign tu = up_row [c*TOWER_W +: TOWER_W];
    assign tm = mid_row[c*TOWER_W +: TOWER_W];
    assign td = dn_row [c*TOWER_W +: TOWER_W];
    assign vsum[c] = {{EXT{tu[TOWER_W-1]}}, tu}
                   + {{EXT{tm[TOWER_W-1]}}, tm}
                   + {{EXT{td[TOWER_W-1]}}, td};

    if ((c % HALF) != 0) begin : g_has_left
      assign lterm[c] = vsum[c-1];
    end else begin : g_cut_left
      assign lterm[c] = '0;
    end

    if ((c % HALF) != (HALF - 1)) begin : g_has_right
      assign rterm[c] = vsum[c+1];
    end else begin : g_cut_right
      assign rterm[c] = '0;
    end

    tbs_cell #(
      .TOWER_W(TOWER_W),
      .SUM_W  (SUM_W),
      .OUT_W  (OUT_W)
    ) u_cell (
      .vs_l  (lterm[c]),
      .vs_c  (vsum[c]),
      .vs_r  (rterm[c]),
      .thr   (thr),
      .sum_o (sums[c*OUT_W +: OUT_W]),
      .seed_o(seeds[c])
    );
  end
endmodule

// File: rtl/tbs_rowbuf.sv
// Sliding two-row history plus the saved first two rows of the frame.
module tbs_rowbuf #(
  parameter int ROW_W = 192,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [ROW_W-1:0] row_in,
  output logic [ROW_W-1:0] prev2,
  output logic [ROW_W-1:0] prev1,
  output logic [ROW_W-1:0] keep0,
  output logic [ROW_W-1:0] keep1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev2 <= '0;
      prev1 <= '0;
      keep0 <= '0;
      keep1 <= '0;
    end else if (load) begin
      prev2 <= prev1;
      prev1 <= row_in;
      if (load_idx == IDX_W'(0)) keep0 <= row_in;
      if (load_idx == IDX_W'(1)) keep1 <= row_in;
    end
  end
endmodule

// File: rtl/tbs_ctrl.sv
// Frame sequencing, input/output handshake and output-valid register.
module tbs_ctrl
  import tbs_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             load,
  output logic [IDX_W-1:0] beat_idx,
  output logic             emit,
  output logic [IDX_W-1:0] emit_idx,
  output tbs_sel_e         sel,
  output logic             out_valid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROWS - 1);

  tbs_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q;
  logic             vld_q;
  logic             slot_free;
  logic             acc;

  assign slot_free = !vld_q || out_ready;
  assign in_ready  = ((st_q == ST_IDLE) || (st_q == ST_RUN)) && slot_free;
  assign acc       = in_valid && in_ready;
  assign beat_idx  = in_sof ? '0 : cnt_q;
  assign load      = acc && (in_sof || (st_q == ST_RUN));
  assign out_valid = vld_q;

  always_comb begin
    st_d     = st_q;
    emit     = 1'b0;
    emit_idx = cnt_q - 1'b1;
    sel      = SEL_RUN;
    case (st_q)
      ST_IDLE, ST_RUN: begin
        if (load) begin
          st_d = (beat_idx == LAST_IDX) ? ST_LAST : ST_RUN;
          if (!in_sof && (cnt_q >= IDX_W'(2))) emit = 1'b1;
        end
      end
      ST_LAST: begin
        if (slot_free) begin
          emit     = 1'b1;
          emit_idx = LAST_IDX;
          sel      = SEL_LAST;
          st_d     = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (slot_free) begin
          emit     = 1'b1;
          emit_idx = '0;
          sel      = SEL_FIRST;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) cnt_q <= beat_idx + 1'b1;
      if (emit)           vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tower_block_summer.sv
module tower_block_summer
  import tbs_pkg::*;
#(
  parameter int ROWS    = DEF_ROWS,
  parameter int COLS    = DEF_COLS,
  parameter int HALF    = DEF_HALF,
  parameter int TOWER_W = DEF_TOWER_W,
  parameter int OUT_W   = DEF_OUT_W,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int SUM_W  = TOWER_W + 4,
  localparam int ROW_W  = COLS * TOWER_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sof,
  input  logic [ROW_W-1:0]          in_row,
  input  logic signed [TOWER_W-1:0] seed_thr,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [IDX_W-1:0]          out_row_idx,
  output logic [COLS*OUT_W-1:0]     out_sum,
  output logic [COLS-1:0]           out_seed
);
  logic                   load, emit;
  logic [IDX_W-1:0]       beat_idx, emit_idx;
  tbs_sel_e               sel;
  logic [ROW_W-1:0]       prev2, prev1, keep0, keep1;
  logic [ROW_W-1:0]       w_up, w_mid, w_dn;
  logic [COLS*OUT_W-1:0]  row_sums;
  logic [COLS-1:0]        row_seeds;

  tbs_ctrl #(.ROWS(ROWS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .load     (load),
    .beat_idx (beat_idx),
    .emit     (emit),
    .emit_idx (emit_idx),
    .sel      (sel),
    .out_valid(out_valid)
  );

  tbs_rowbuf #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_rowbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_idx(beat_idx),
    .row_in  (in_row),
    .prev2   (prev2),
    .prev1   (prev1),
    .keep0   (keep0),
    .keep1   (keep1)
  );

  // pick the three rows of the window being emitted
  always_comb begin
    case (sel)
      SEL_LAST:  begin w_up = prev2; w_mid = prev1; w_dn = keep0;  end
      SEL_FIRST: begin w_up = prev1; w_mid = keep0; w_dn = keep1;  end
      default:   begin w_up = prev2; w_mid = prev1; w_dn = in_row; end
    endcase
  end

  tbs_rowsum #(
    .COLS   (COLS),
    .HALF   (HALF),
    .TOWER_W(TOWER_W),
    .SUM_W  (SUM_W),
    .OUT_W  (OUT_W)
  ) u_rowsum (
    .up_row (w_up),
    .mid_row(w_mid),
    .dn_row (w_dn),
    .thr    (seed_thr),
    .sums   (row_sums),
    .seeds  (row_seeds)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sum     <= '0;
      out_seed    <= '0;
      out_row_idx <= '0;
    end else if (emit) begin
      out_sum     <= row_sums;
      out_seed    <= row_seeds;
      out_row_idx <= emit_idx;
    end
  end
endmodule

// File: rtl/tbs_chk.sv
module tbs_chk #(
  parameter int ROWS  = 32,
  parameter int IDX_W = 5,
  parameter int SUMS_W = 144,
  parameter int COLS  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_row_idx,
  input logic [SUMS_W-1:0] out_sum,
  input logic [COLS-1:0]   out_seed
);
  // output beat is frozen while the consumer stalls
  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) &&
                                   $stable(out_seed) && $stable(out_row_idx)));

  // input is held off while the last row of the frame is pending
  assert_flush_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_row_idx == IDX_W'(ROWS - 1))) |-> !in_ready);

  // the wrap row is followed at once by row 0
  assert_wrap_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_row_idx == IDX_W'(ROWS - 1)))
      |=> (out_valid && (out_row_idx == '0)));

  // a frame start never produces an output beat of its own
  assert_sof_no_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> !out_valid);
endmodule

bind tower_block_summer tbs_chk #(
  .ROWS  (ROWS),
  .IDX_W (IDX_W),
  .SUMS_W(COLS*OUT_W),
  .COLS  (COLS)
) u_tbs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sof     (in_sof),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_row_idx(out_row_idx),
  .out_sum    (out_sum),
  .out_seed   (out_seed)
);

// File: tb/test_tower_block_summer.sv
module test_tower_block_summer;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 32;
  localparam int COLS = 12;
  localparam int HALF = 6;
  localparam int TW   = 16;
  localparam int OW   = 12;
  localparam int MAXV = 4095;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_ready;
  logic [COLS*TW-1:0] in_row;
  logic signed [TW-1:0] seed_thr;
  logic out_valid;
  logic out_ready;
  logic [4:0] out_row_idx;
  logic [COLS*OW-1:0] out_sum;
  logic [COLS-1:0] out_seed;

  int g [ROWS][COLS];
  int thr_ref;
  int n_chk = 0, n_fail = 0, n_out = 0, exp_idx = 1, bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  tower_block_summer i_tower_block_summer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_row(in_row), .seed_thr(seed_thr),
    .out_valid(out_valid), .out_ready(out_ready), .out_row_idx(out_row_idx),
    .out_sum(out_sum), .out_seed(out_seed)
  );

  function automatic int raw_sum(int r, int c);
    int s = 0;
    int lo = ((c % HALF) == 0) ? c : c - 1;
    int hi = ((c % HALF) == HALF - 1) ? c : c + 1;
    for (int dr = -1; dr <= 1; dr++) begin
      int rr = (r + dr + ROWS) % ROWS;
      for (int cc = lo; cc <= hi; cc++) s += g[rr][cc];
    end
    return s;
  endfunction

  function automatic string tag_for(int r, int c, int raw);
    if (raw < 0 || raw > MAXV) return "R5";
    if (r == 0 || r == ROWS - 1) return "R3";
    if ((c % HALF) == 0 || (c % HALF) == HALF - 1) return "R2";
    return "R1";
  endfunction

  function automatic logic [COLS*TW-1:0] pack_row(int r);
    logic [COLS*TW-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*TW +: TW] = TW'(g[r][c]);
    return v;
  endfunction

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
    end
  endtask

  task automatic check_row();
    int idx = int'(out_row_idx);
    bit ok = 1'b1;
    check(idx == exp_idx, "R6 output row order", idx, exp_idx);
    n_chk++;
    for (int c = 0; c < COLS; c++) begin
      int raw = raw_sum(idx, c);
      int es = (raw < 0) ? 0 : ((raw > MAXV) ? MAXV : raw);
      int ep = (raw > thr_ref) ? 1 : 0;
      int as = int'(out_sum[c*OW +: OW]);
      int ap = int'(out_seed[c]);
      if (ok && as != es) begin
        ok = 1'b0;
        $display("FAIL %s sum row %0d col %0d: actual %0d expected %0d",
                 tag_for(idx, c, raw), idx, c, as, es);
      end else if (ok && ap != ep) begin
        ok = 1'b0;
        $display("FAIL R4 seed row %0d col %0d: actual %0d expected %0d", idx, c, ap, ep);
      end
    end
    if (!ok) n_fail++;
    exp_idx = (exp_idx == ROWS - 1) ? 0 : exp_idx + 1;
    n_out++;
  endtask

  // consumer: ready pattern and per-row comparison
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (bp_mode == 0) ? 1'b1 : ((bp_mode == 1) ? (lfsr[0] | lfsr[2]) : 1'b0);
    if (rst_n && out_valid && out_ready) check_row();
  end

  task automatic send_rows(input int first, input int last, input bit with_sof);
    for (int r = first; r <= last; r++) begin
      @(negedge clk); #1;
      in_valid = 1'b1;
      in_sof   = with_sof && (r == 0);
      in_row   = pack_row(r);
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic wait_outs(input int target);
    while (n_out < target) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic fill(input int lo, input int hi);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        g[r][c] = lo + int'($urandom_range(hi - lo));
  endtask

  task automatic set_thr(input int t);
    thr_ref = t;
    seed_thr = TW'(t);
  endtask

  task automatic run_frame(input string what);
    int base = n_out;
    exp_idx = 1;
    send_rows(0, ROWS - 1, 1'b1);
    wait_outs(base + ROWS);
    idle(4);
    check(n_out == base + ROWS, {"R6 beats per frame, ", what}, n_out - base, ROWS);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R6 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R7 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_positive();   // R1 inner windows on small positive towers
    fill(0, 300); set_thr(1200); bp_mode = 0;
    run_frame("positive R1");
  endtask

  task automatic t_negative();   // R4 R5 negative sums, negative threshold
    fill(-2000, 2000); set_thr(-100); bp_mode = 0;
    run_frame("negative R5");
  endtask

  task automatic t_saturate();   // R5 upper clamp with seed above full scale
    fill(0, 6000); set_thr(20000); bp_mode = 0;
    run_frame("saturate R5");
  endtask

  task automatic t_edges();      // R2 R3 R4 isolated towers near wrap and seam
    fill(0, 0);
    g[0][5] = 1000; g[31][6] = -300; g[15][0] = 5000; g[1][11] = 7;
    set_thr(7); bp_mode = 0;
    run_frame("edges R2 R3");
  endtask

  task automatic t_backpressure(); // R7 random consumer stalls
    fill(-500, 1500); set_thr(2000); bp_mode = 1;
    run_frame("backpressure R7");
    bp_mode = 0;
  endtask

  task automatic t_stall();      // R7 full stall blocks input and freezes output
    int base = n_out;
    logic [COLS*OW-1:0] snap;
    fill(0, 900); set_thr(3000); exp_idx = 1; bp_mode = 2;
    fork send_rows(0, ROWS - 1, 1'b1); join_none
    idle(8);
    snap = out_sum;
    check(in_ready == 1'b0, "R7 input blocked on stall", int'(in_ready), 0);
    check(out_valid && out_row_idx == 5'd1, "R7 first row waiting", int'(out_row_idx), 1);
    idle(4);
    check(out_sum == snap && out_valid, "R7 output frozen on stall", int'(out_sum[11:0]), int'(snap[11:0]));
    bp_mode = 0;
    wait_outs(base + ROWS);
    idle(4);
  endtask

  task automatic t_idle_ignore(); // R8 beats outside a frame are dropped
    int base = n_out;
    fill(100, 200);
    send_rows(1, 3, 1'b0);
    idle(6);
    check(n_out == base, "R8 no output from stray beats", n_out - base, 0);
    check(out_valid == 1'b0, "R8 out_valid stays low", int'(out_valid), 0);
  endtask

  task automatic t_restart();    // R9 frame start mid-frame
    int base = n_out;
    fill(0, 400); set_thr(900); exp_idx = 1; bp_mode = 0;
    send_rows(0, 9, 1'b1);
    idle(6);
    check(n_out == base + 8, "R9 partial frame outputs", n_out - base, 8);
    fill(-100, 700);
    run_frame("after restart R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual %0d outputs expected completion", n_out);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_row = '0; seed_thr = '0;
    thr_ref = 0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_positive();
    t_negative();
    t_saturate();
    t_edges();
    t_backpressure();
    t_stall();
    t_idle_ignore();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule